// File: doc/BRIEF.md
# Flash Protected-Range Access Guard

This block stands in the command path of a serial flash controller. It decides, one command at a time, whether the flash may carry out that command. Software programs a small set of address windows. Each window has a lower page bound, an upper page bound, a flag that forbids reads and a flag that forbids writes. Every command issued through the programmed-register path is compared against all windows. If its address falls inside a window whose flag matches the command's class, the command is refused. Erase counts as a write. Commands from the direct memory-mapped read path are never examined and are always let through.

A global write-protect flag refuses every programmed write or erase, whatever the window settings. A lock flag, once set, freezes every window register until reset. Writes to a frozen register are silently dropped. A refused command raises a one-cycle refusal strobe and sets a sticky error flag. Software clears that flag by writing a 1 to it.

The verdict for a command presented in one cycle appears on the outputs in the next cycle.

Top module: `flash_range_guard`

## Requirements
- R1: A window covers every address whose page (address bits [24:12]) lies between its base and limit inclusive. A window whose base is above its limit covers nothing.
- R2: A programmed read (cmd_type 0) is refused only when it hits a window with its read-protect bit set. A window with only write protect passes reads.
- R3: A programmed write (cmd_type 1) or erase (cmd_type 2) is refused when it hits a window with its write-protect bit set. A window with only read protect passes it.
- R4: A command with cmd_prog low (direct read path) is always granted and never sets the error flag, whatever the window, global and lock settings.
- R5: With global write protect (control bit 0) set, every programmed write or erase is refused, and reads are judged by the windows alone.
- R6: Writing 1 to control bit 1 sets the lock. Once locked, writes to window registers are ignored without error, and the lock cannot be cleared until reset. Global write protect stays writable.
- R7: The cycle after cmd_valid, exactly one of cmd_grant or cmd_block is high for one cycle. Both are low in any cycle not following a valid command.
- R8: A refusal sets the error flag (control bit 2). Writing 1 there clears it, and writing 0 leaves it unchanged.
- R9: After reset, all window registers and control bits read 0, and neither cmd_grant nor cmd_block is high.
- R10: Window register n sits at cfg_addr n (0 to 4), with base in bits [12:0], limit in [25:13], read protect in bit 26 and write protect in bit 27. The control register sits at cfg_addr 15. Reads return these fields, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 28 | Register write data |
| cfg_rdata | output | 28 | Register read data (combinational on cfg_addr) |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_prog | input | 1 | 1 = programmed-register path, 0 = direct read path |
| cmd_type | input | 2 | 0 read, 1 write, 2 erase, 3 treated as write |
| cmd_addr | input | 25 | Flash byte address of the command |
| cmd_grant | output | 1 | Command allowed (cycle after cmd_valid) |
| cmd_block | output | 1 | Command refused; one-cycle error strobe |

## Verification
The properties assume that cmd_prog, cmd_type and cmd_addr are meaningful only while cmd_valid is high. They also assume that a command may arrive in the same cycle as a register write, in which case it is judged against the settings from before that write. The stimulus presents one command at a time, with idle cycles between commands. It keeps register writes and commands in separate cycles, so the bench model can apply register changes before judging the next command. Addresses are mostly drawn at and next to window edges, where an off-by-one in the inclusive compare would show.

// File: rtl/frg_pkg.sv
package frg_pkg;
    localparam int CFG_AW = 4;
    localparam logic [CFG_AW-1:0] CTRL_ADDR = 4'hF;

    localparam int CTL_GWP  = 0;
    localparam int CTL_LOCK = 1;
    localparam int CTL_ERR  = 2;

    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_ERASE = 2'd2,
        CMD_OTHER = 2'd3
    } cmd_kind_e;
endpackage

// File: rtl/frg_range_cmp.sv
module frg_range_cmp #(
    parameter int ADDR_W     = 25,
    parameter int PAGE_SHIFT = 12,
    localparam int PG_W      = ADDR_W - PAGE_SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PG_W-1:0]   base,
    input  logic [PG_W-1:0]   limit,
    input  logic              rd_prot,
    input  logic              wr_prot,
    input  logic              is_write,
    output logic              hit
);
    logic [ADDR_W-1:0] lo_addr;
    logic [ADDR_W-1:0] hi_addr;
    logic              in_window;

    always_comb begin
        lo_addr   = {base,  {PAGE_SHIFT{1'b0}}};
        hi_addr   = {limit, {PAGE_SHIFT{1'b1}}};
        in_window = (addr >= lo_addr) && (addr <= hi_addr);
        hit       = in_window && (is_write ? wr_prot : rd_prot);
    end
endmodule

// File: rtl/frg_cfg_regs.sv
module frg_cfg_regs
    import frg_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int PG_W       = 13,
    localparam int DW        = 2 * PG_W + 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [CFG_AW-1:0]                addr,
    input  logic [DW-1:0]                    wdata,
    output logic [DW-1:0]                    rdata,
    input  logic                             err_set,
    output logic [NUM_RANGES-1:0][PG_W-1:0]  base_o,
    output logic [NUM_RANGES-1:0][PG_W-1:0]  limit_o,
    output logic [NUM_RANGES-1:0]            rd_o,
    output logic [NUM_RANGES-1:0]            wr_o,
    output logic                             gwp_o,
    output logic                             lock_o,
    output logic                             err_o
);
    typedef struct packed {
        logic [NUM_RANGES-1:0][PG_W-1:0] base;
        logic [NUM_RANGES-1:0][PG_W-1:0] limit;
        logic [NUM_RANGES-1:0]           rd;
        logic [NUM_RANGES-1:0]           wr;
        logic                            gwp;
        logic                            lock;
        logic                            err;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (addr == CTRL_ADDR) begin
                st_d.gwp  = wdata[CTL_GWP];
                st_d.lock = st_q.lock | wdata[CTL_LOCK];
                if (wdata[CTL_ERR]) st_d.err = 1'b0;
            end else if (!st_q.lock) begin
                for (int i = 0; i < NUM_RANGES; i++) begin
                    if (addr == CFG_AW'(i)) begin
                        st_d.base[i]  = wdata[PG_W-1:0];
                        st_d.limit[i] = wdata[2*PG_W-1:PG_W];
                        st_d.rd[i]    = wdata[2*PG_W];
                        st_d.wr[i]    = wdata[2*PG_W+1];
                    end
                end
            end
        end
        if (err_set) st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == CTRL_ADDR) begin
            rdata[CTL_GWP]  = st_q.gwp;
            rdata[CTL_LOCK] = st_q.lock;
            rdata[CTL_ERR]  = st_q.err;
        end else begin
            for (int i = 0; i < NUM_RANGES; i++) begin
                if (addr == CFG_AW'(i)) begin
                    rdata = {st_q.wr[i], st_q.rd[i], st_q.limit[i], st_q.base[i]};
                end
            end
        end
    end

    assign base_o  = st_q.base;
    assign limit_o = st_q.limit;
    assign rd_o    = st_q.rd;
    assign wr_o    = st_q.wr;
    assign gwp_o   = st_q.gwp;
    assign lock_o  = st_q.lock;
    assign err_o   = st_q.err;
endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard
    import frg_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int ADDR_W     = 25,
    parameter int PAGE_SHIFT = 12,
    localparam int PG_W      = ADDR_W - PAGE_SHIFT,
    localparam int DW        = 2 * PG_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic              cmd_valid,
    input  logic              cmd_prog,
    input  logic [1:0]        cmd_type,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_grant,
    output logic              cmd_block
);
    typedef struct packed {
        logic grant;
        logic block;
    } resp_t;

    logic [NUM_RANGES-1:0][PG_W-1:0] base_w;
    logic [NUM_RANGES-1:0][PG_W-1:0] limit_w;
    logic [NUM_RANGES-1:0]           rd_w;
    logic [NUM_RANGES-1:0]           wr_w;
    logic [NUM_RANGES-1:0]           hit_w;
    logic                            gwp_w;
    logic                            lock_w;
    logic                            err_w;
    logic                            is_write;
    logic                            refuse;
    logic                            err_set;
    resp_t                           resp_d, resp_q;

    assign is_write = (cmd_type != CMD_READ);

    frg_cfg_regs #(
        .NUM_RANGES (NUM_RANGES),
        .PG_W       (PG_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .err_set (err_set),
        .base_o  (base_w),
        .limit_o (limit_w),
        .rd_o    (rd_w),
        .wr_o    (wr_w),
        .gwp_o   (gwp_w),
        .lock_o  (lock_w),
        .err_o   (err_w)
    );

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
        frg_range_cmp #(
            .ADDR_W     (ADDR_W),
            .PAGE_SHIFT (PAGE_SHIFT)
        ) u_cmp (
            .addr     (cmd_addr),
            .base     (base_w[g]),
            .limit    (limit_w[g]),
            .rd_prot  (rd_w[g]),
            .wr_prot  (wr_w[g]),
            .is_write (is_write),
            .hit      (hit_w[g])
        );
    end

    always_comb begin
        refuse       = cmd_prog && ((|hit_w) || (gwp_w && is_write));
        err_set      = cmd_valid && refuse;
        resp_d.grant = cmd_valid && !refuse;
        resp_d.block = cmd_valid && refuse;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign cmd_grant = resp_q.grant;
    assign cmd_block = resp_q.block;
endmodule

// File: rtl/frg_checker.sv
module frg_checker #(
    parameter int RW = 140
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_prog,
    input logic [1:0]    cmd_type,
    input logic          cmd_grant,
    input logic          cmd_block,
    input logic          gwp,
    input logic          lock,
    input logic          err,
    input logic [RW-1:0] ranges
);
    // R7: grant and refusal never together
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_grant && cmd_block));

    // R7: a verdict only follows a valid command
    a_r7_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_grant || cmd_block) |-> $past(cmd_valid));

    // R7: every valid command gets a verdict
    a_r7_answered: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (cmd_grant || cmd_block));

    // R4: the direct path is always granted
    a_r4_direct_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_prog) |=> cmd_grant);

    // R5: global write protect refuses programmed writes and erases
    a_r5_global_wp: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_prog && cmd_type != 2'd0 && gwp) |=> cmd_block);

    // R8: a refusal leaves the error flag set
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_block |-> err);

    // R6: the lock holds until reset
    a_r6_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    // R6: window settings frozen while locked
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(ranges));
endmodule

bind flash_range_guard frg_checker #(
    .RW (NUM_RANGES * (2 * (ADDR_W - PAGE_SHIFT) + 2))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_prog  (cmd_prog),
    .cmd_type  (cmd_type),
    .cmd_grant (cmd_grant),
    .cmd_block (cmd_block),
    .gwp       (gwp_w),
    .lock      (lock_w),
    .err       (err_w),
    .ranges    ({base_w, limit_w, rd_w, wr_w})
);

// File: tb/sim_flash_range_guard.sv
module sim_flash_range_guard;
    localparam int CLK_P = 10;
    localparam int NR    = 5;
    localparam int AW    = 25;
    localparam int PG    = 13;
    localparam int DW    = 2 * PG + 2;
    localparam logic [3:0] CTRL = 4'hF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic          cmd_valid = 1'b0;
    logic          cmd_prog = 1'b0;
    logic [1:0]    cmd_type = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_grant;
    logic          cmd_block;

    int checks = 0;
    int errors = 0;

    logic [PG-1:0] m_base [NR];
    logic [PG-1:0] m_lim  [NR];
    logic          m_rp   [NR];
    logic          m_wp   [NR];
    logic          m_gwp = 1'b0;
    logic          m_lock = 1'b0;
    logic          m_err = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    flash_range_guard u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cmd_valid (cmd_valid),
        .cmd_prog  (cmd_prog),
        .cmd_type  (cmd_type),
        .cmd_addr  (cmd_addr),
        .cmd_grant (cmd_grant),
        .cmd_block (cmd_block)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rng_word(logic wp, logic rp, logic [PG-1:0] lim, logic [PG-1:0] b);
        return {wp, rp, lim, b};
    endfunction

    function automatic bit exp_refuse(logic prog, logic [1:0] typ, logic [AW-1:0] a);
        logic [PG-1:0] pg;
        bit wr;
        bit r;
        pg = a[AW-1:AW-PG];
        wr = (typ != 2'd0);
        r  = 1'b0;
        if (!prog) return 1'b0;
        if (wr && m_gwp) r = 1'b1;
        for (int i = 0; i < NR; i++)
            if (pg >= m_base[i] && pg <= m_lim[i] && (wr ? m_wp[i] : m_rp[i])) r = 1'b1;
        return r;
    endfunction

    task automatic cfg_write(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == CTRL) begin
            m_gwp  = d[0];
            m_lock = m_lock | d[1];
            if (d[2]) m_err = 1'b0;
        end else if (a < NR && !m_lock) begin
            m_base[a] = d[PG-1:0];
            m_lim[a]  = d[2*PG-1:PG];
            m_rp[a]   = d[2*PG];
            m_wp[a]   = d[2*PG+1];
        end
    endtask

    task automatic cfg_read(input logic [3:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic issue(input logic prog, input logic [1:0] typ, input logic [AW-1:0] a, input string req);
        bit e;
        e = exp_refuse(prog, typ, a);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_prog = prog; cmd_type = typ; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_block == e && cmd_grant == !e, req, {cmd_grant, cmd_block}, {!e, e});
        if (e) m_err = 1'b1;
    endtask

    function automatic logic [AW-1:0] pa(logic [PG-1:0] pg, logic [11:0] off);
        return {pg, off};
    endfunction

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        void'($urandom(32'd4242));
        for (int i = 0; i < NR; i++) begin
            m_base[i] = '0; m_lim[i] = '0; m_rp[i] = 1'b0; m_wp[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        check(!cmd_grant && !cmd_block, "R9 outputs", {cmd_grant, cmd_block}, 0);
        cfg_read(4'd0, rd);
        check(rd == '0, "R9 range0", rd, 0);
        cfg_read(CTRL, rd);
        check(rd == '0, "R9 ctrl", rd, 0);

        // R10: programming and readback
        cfg_write(4'd0, rng_word(1, 1, 13'h01F, 13'h010));
        cfg_write(4'd1, rng_word(1, 0, 13'h100, 13'h100));
        cfg_write(4'd2, rng_word(1, 1, 13'h1FF, 13'h200));
        cfg_write(4'd3, rng_word(0, 1, 13'h3FF, 13'h300));
        cfg_write(4'd4, rng_word(0, 0, 13'h7FF, 13'h400));
        cfg_read(4'd1, rd);
        check(rd == rng_word(1, 0, 13'h100, 13'h100), "R10 readback", rd, rng_word(1, 0, 13'h100, 13'h100));
        cfg_read(4'd7, rd);
        check(rd == '0, "R10 unmapped", rd, 0);

        // R1: inclusive edges and empty window
        issue(1, 2'd0, pa(13'h00F, 12'hFFF), "R1 below base");
        issue(1, 2'd0, pa(13'h010, 12'h000), "R1 at base");
        issue(1, 2'd1, pa(13'h01F, 12'hFFF), "R1 at limit");
        issue(1, 2'd1, pa(13'h020, 12'h000), "R1 above limit");
        issue(1, 2'd1, pa(13'h200, 12'h010), "R1 empty window");
        issue(1, 2'd1, pa(13'h500, 12'h010), "R1 disabled window");
        // R2 / R3: per-class protection
        issue(1, 2'd0, pa(13'h100, 12'h123), "R2 read passes write-only window");
        issue(1, 2'd0, pa(13'h3A0, 12'h000), "R2 read refused");
        issue(1, 2'd1, pa(13'h100, 12'h000), "R3 write refused");
        issue(1, 2'd2, pa(13'h100, 12'hFFF), "R3 erase refused");
        issue(1, 2'd3, pa(13'h100, 12'h800), "R3 code 3 as write");
        issue(1, 2'd2, pa(13'h3A0, 12'h000), "R3 erase passes read-only window");

        // R8: sticky error, W1C
        cfg_read(CTRL, rd);
        check(rd[2] == 1'b1, "R8 err set", rd, 4);
        cfg_write(CTRL, 28'h0);
        cfg_read(CTRL, rd);
        check(rd[2] == 1'b1, "R8 write 0 keeps", rd, 4);
        cfg_write(CTRL, 28'h4);
        cfg_read(CTRL, rd);
        check(rd[2] == 1'b0, "R8 write 1 clears", rd, 0);

        // R4: direct path ignores protection and leaves error clear
        issue(0, 2'd0, pa(13'h010, 12'h000), "R4 direct in window");
        issue(0, 2'd1, pa(13'h100, 12'h000), "R4 direct write code");
        cfg_read(CTRL, rd);
        check(rd[2] == 1'b0, "R4 no error", rd, 0);

        // R5: global write protect
        cfg_write(CTRL, 28'h1);
        issue(1, 2'd1, pa(13'h1000, 12'h000), "R5 write refused");
        issue(1, 2'd2, pa(13'h0000, 12'h000), "R5 erase refused");
        issue(1, 2'd0, pa(13'h1000, 12'h000), "R5 read passes");
        issue(0, 2'd1, pa(13'h1000, 12'h000), "R4 direct under gwp");
        cfg_write(CTRL, 28'h4);

        // R7: outputs idle after the verdict cycle
        @(negedge clk);
        check(!cmd_grant && !cmd_block, "R7 idle", {cmd_grant, cmd_block}, 0);

        // random traffic against the model
        for (int n = 0; n < 400; n++) begin
            logic [PG-1:0] pg;
            int k;
            k = int'($urandom_range(0, NR - 1));
            case ($urandom_range(0, 4))
                0: pg = m_base[k] - 13'd1;
                1: pg = m_base[k];
                2: pg = m_lim[k];
                3: pg = m_lim[k] + 13'd1;
                default: pg = PG'($urandom);
            endcase
            if ($urandom_range(0, 29) == 0) cfg_write(CTRL, {26'd0, 1'b0, 1'($urandom)});
            issue(1'($urandom_range(0, 3) != 0), 2'($urandom), pa(pg, 12'($urandom)), "R1 R2 R3 R5 random");
        end

        // R6: lock freezes windows
        cfg_write(CTRL, 28'h6);
        cfg_write(4'd0, rng_word(0, 0, 13'h000, 13'h000));
        cfg_read(4'd0, rd);
        check(rd == rng_word(1, 1, 13'h01F, 13'h010), "R6 range frozen", rd, rng_word(1, 1, 13'h01F, 13'h010));
        cfg_write(CTRL, 28'h0);
        cfg_read(CTRL, rd);
        check(rd[1] == 1'b1, "R6 lock stays", rd, 2);
        cfg_write(CTRL, 28'h1);
        cfg_read(CTRL, rd);
        check(rd[0] == 1'b1, "R6 gwp writable", rd, 3);
        issue(1, 2'd0, pa(13'h015, 12'h000), "R6 old window active");

        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule